// File: doc/BRIEF.md
# Multi-Mode Down Counter Channel

This block is one channel of a programmable interval timer. A 16-bit counter steps down on each falling edge of an external counting clock. The counting clock and the gate input are sampled into the system clock domain and turned into single-cycle edge events. The host presents a mode number and a preset value together with a one-cycle load strobe. The channel checks that the pair is legal, stores it, and starts counting under the rules of the chosen mode. The live count is always visible so that a host interface can latch it.

There are six modes, numbered 0 to 5:

- 0: terminal-count flag
- 1: gate-triggered one-shot that can be retriggered
- 2: periodic divider
- 3: square wave
- 4: strobe started by the load
- 5: strobe started by the gate

The modes differ in three ways: whether a gate rising edge restarts counting, how the counter reloads, and how the output pin behaves. BCD counting and the host bus belong to other blocks.

Top module: `pit_channel`

## Requirements
- R1: After reset the count reads 0, the output is high, the mode is 0, the preset is 0, and the counter is stopped.
- R2: A load is accepted only when the mode is 0..5, and a preset of 1 is not accepted with mode 2 or 3. A rejected load leaves the mode, the preset, the count and the output unchanged, and counting continues as before.
- R3: In modes 0, 2, 3 and 4 the counter takes its start value at the first counting-clock falling edge after a load. In modes 1 and 5 a load stops the counter and the count holds until a gate rising edge. The count then loads at the next falling edge. In all modes except mode 3 the count drops by one per falling edge and wraps from 0 to 65535.
- R4: A gate rising edge in modes 1, 2, 3 and 5 makes the counter reload its start value at the next falling edge. In modes 0 and 4 a gate edge has no effect on the count or the output.
- R5: In mode 0 the output goes low one system clock after an accepted load. It goes high when the count steps from 1 to 0 and stays high while counting wraps on.
- R6: In mode 1 the output goes low at the falling edge that loads the count. It goes high when the count steps from 1 to 0.
- R7: In mode 2 the output is low while the count is 1. At the next falling edge the count reloads the preset and the output returns high. With a preset of 0 the count passes 0 and then 65535.
- R8: In mode 3 the start value is the preset with bit 0 cleared, and the count steps down by 2. When the count is 2, the next falling edge reloads and toggles the output, which starts high. For an odd preset the high phase lasts one extra falling edge. A preset of 0 gives 0 and then 65534.
- R9: In modes 4 and 5 the output is low for exactly one counting period, from the falling edge where the count first reaches 0 to the next falling edge. It does not pulse again until the next load.
- R10: The counting clock and the gate each pass through a two-stage synchronizer. A rising counting-clock edge never steps the count, and each falling edge steps it once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clk | input | 1 | External counting clock, counted on falling edges |
| gate | input | 1 | External gate, rising edges used in modes 1, 2, 3, 5 |
| mode_i | input | 3 | Mode number offered with a load |
| preset_i | input | 16 | Preset offered with a load (0 means full range) |
| load_i | input | 1 | One-cycle load strobe |
| count_o | output | 16 | Current count value |
| out_o | output | 1 | Channel output pin |

## Verification
Every internal state of this channel shows up at the ports within one counting period. A wrong count is visible on `count_o` right after the falling edge that produced it. A wrong phase, stall or done flag first appears on `out_o` one falling edge later, as a pulse or toggle at the wrong place. The bench therefore samples both outputs after every falling edge. It runs each mode through a complete reload or terminal cycle, and it separates odd, even, zero and illegal presets.

// File: rtl/pit_pkg.sv
// Package: shared mode encoding and per-mode property helpers for the
// timer channel. Assumes a 3-bit mode field; values 6 and 7 are illegal.
package pit_pkg;

    typedef enum logic [2:0] {
        MD_TC_FLAG   = 3'd0,
        MD_ONE_SHOT  = 3'd1,
        MD_DIVIDER   = 3'd2,
        MD_SQUARE    = 3'd3,
        MD_SW_STROBE = 3'd4,
        MD_HW_STROBE = 3'd5
    } pit_mode_e;

    // True when a gate rising edge (re)starts counting in this mode.
    function automatic logic gate_restarts(input logic [2:0] m);
        return (m == MD_ONE_SHOT) || (m == MD_DIVIDER) ||
               (m == MD_SQUARE)   || (m == MD_HW_STROBE);
    endfunction

    // True when counting waits for a gate edge after a load.
    function automatic logic needs_gate_start(input logic [2:0] m);
        return (m == MD_ONE_SHOT) || (m == MD_HW_STROBE);
    endfunction

endpackage

// File: rtl/pit_edge_sync.sv
// Synchronizes WIDTH asynchronous inputs through STAGES flops and flags
// rising and falling edges as one-system-cycle pulses.
// Assumes the inputs stay stable for at least STAGES+1 system clocks.
module pit_edge_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift one synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= '0;
                else if (gi == 0) chain_q[gi] <= async_i;
                else chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi - 1];
            end
        end
    endgenerate

    // Keep the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pit_cfg.sv
// Holds the active mode and preset. Accepts a load only when the mode is
// defined and the preset is legal for it; rejected loads change nothing.
module pit_cfg
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic             accept_o,
    output logic [2:0]       mode_o,
    output logic [CNT_W-1:0] preset_o
);
    logic mode_ok, preset_ok;

    // Decide legality of the offered mode/preset pair.
    always_comb begin
        mode_ok   = (mode_i <= 3'd5);
        preset_ok = !(((mode_i == MD_DIVIDER) || (mode_i == MD_SQUARE)) &&
                      (preset_i == CNT_W'(1)));
    end

    assign accept_o = load_i && mode_ok && preset_ok;

    // Register an accepted configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o   <= MD_TC_FLAG;
            preset_o <= '0;
        end else if (accept_o) begin
            mode_o   <= mode_i;
            preset_o <= preset_i;
        end
    end

    AST_PRESET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == MD_DIVIDER) || (mode_o == MD_SQUARE)) |-> (preset_o != CNT_W'(1))); // R2

endmodule

// File: rtl/pit_core.sv
// Down counter and output-pin state machine for all six modes. Steps on
// tick_i (a falling counting-clock edge). Assumes accept_i and mode_nxt_i
// describe a load taking effect at this edge; mode_i/preset_i hold the
// configuration currently in force.
module pit_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [2:0]       mode_nxt_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic             tick_i,
    input  logic             gate_rise_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] cnt_q, start_val;
    logic out_q, pend_q, run_q, stall_q, done_q;

    // Start/reload value: square mode drops bit 0 of the preset.
    assign start_val = (mode_i == MD_SQUARE) ? {preset_i[CNT_W-1:1], 1'b0} : preset_i;

    // Advance counter and output state on loads, gate edges and ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0; out_q <= 1'b1; pend_q <= 1'b0;
            run_q <= 1'b0; stall_q <= 1'b0; done_q <= 1'b0;
        end else if (accept_i) begin
            pend_q  <= !needs_gate_start(mode_nxt_i);
            run_q   <= 1'b0;
            stall_q <= 1'b0;
            done_q  <= 1'b0;
            out_q   <= (mode_nxt_i != MD_TC_FLAG);
        end else if (gate_rise_i && gate_restarts(mode_i)) begin
            pend_q  <= 1'b1;
            stall_q <= 1'b0;
            if ((mode_i == MD_DIVIDER) || (mode_i == MD_SQUARE)) out_q <= 1'b1;
        end else if (tick_i && pend_q) begin
            cnt_q  <= start_val;
            pend_q <= 1'b0;
            run_q  <= 1'b1;
            done_q <= 1'b0;
            if (mode_i == MD_ONE_SHOT) out_q <= 1'b0;
            else if (mode_i != MD_TC_FLAG) out_q <= 1'b1;
        end else if (tick_i && run_q) begin
            case (mode_i)
                MD_TC_FLAG, MD_ONE_SHOT: begin
                    cnt_q <= cnt_q - ONE;
                    if (cnt_q == ONE) out_q <= 1'b1;
                end
                MD_DIVIDER: begin
                    if (cnt_q == ONE) begin
                        cnt_q <= preset_i;
                        out_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                        out_q <= (cnt_q != TWO);
                    end
                end
                MD_SQUARE: begin
                    if (cnt_q == TWO) begin
                        if (preset_i[0] && out_q && !stall_q) begin
                            stall_q <= 1'b1;
                        end else begin
                            cnt_q   <= start_val;
                            out_q   <= !out_q;
                            stall_q <= 1'b0;
                        end
                    end else begin
                        cnt_q <= cnt_q - TWO;
                    end
                end
                default: begin
                    cnt_q <= cnt_q - ONE;
                    if ((cnt_q == ONE) && !done_q) begin
                        out_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        out_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign count_o = cnt_q;
    assign out_o   = out_q;

    AST_SQUARE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !pend_q && (mode_i == MD_SQUARE)) |-> (cnt_q[0] == 1'b0)); // R8
    AST_DIVIDER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (mode_i == MD_DIVIDER) && (preset_i != '0)) |-> (cnt_q != '0)); // R7
    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode_i == MD_SW_STROBE) || (mode_i == MD_HW_STROBE)) && $fell(out_q))
        |-> $past(tick_i)); // R9
    AST_GATE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode_i == MD_TC_FLAG) || (mode_i == MD_SW_STROBE)) && gate_rise_i &&
         !tick_i && !accept_i) |=> ($stable(out_q) && $stable(cnt_q))); // R4

endmodule

// File: rtl/pit_channel.sv
// Top of one timer channel: synchronizes the counting clock and gate,
// validates host loads, and runs the mode-dependent down counter.
// Assumes cnt_clk and gate change slowly relative to clk.
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clk,
    input  logic             gate,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] preset_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] rise, fall;
    logic             accept;
    logic [2:0]       mode_q;
    logic [CNT_W-1:0] preset_q;

    pit_edge_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({gate, cnt_clk}),
        .rise_o(rise), .fall_o(fall)
    );

    pit_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .mode_i(mode_i),
        .preset_i(preset_i), .accept_o(accept), .mode_o(mode_q),
        .preset_o(preset_q)
    );

    pit_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .mode_nxt_i(mode_i),
        .mode_i(mode_q), .preset_i(preset_q), .tick_i(fall[0]),
        .gate_rise_i(rise[1]), .count_o(count_o), .out_o(out_o)
    );

    AST_RISE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[0] && !fall[0] && !accept) |=> $stable(count_o)); // R10

endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_clk = 1'b0;
    logic gate = 1'b0;
    logic [2:0] mode_i = '0;
    logic [15:0] preset_i = '0;
    logic load_i = 1'b0;
    logic [15:0] count_o;
    logic out_o;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_channel u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .gate(gate),
        .mode_i(mode_i), .preset_i(preset_i), .load_i(load_i),
        .count_o(count_o), .out_o(out_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk2(input string req, input logic [15:0] ec, input logic eo);
        chk({req, " count"}, count_o, ec);
        chk({req, " out"}, {15'd0, out_o}, {15'd0, eo});
    endtask

    task automatic tick();
        cnt_clk = 1'b1;
        repeat (4) @(negedge clk);
        cnt_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic gate_pulse();
        gate = 1'b1;
        repeat (4) @(negedge clk);
        gate = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic load(input logic [2:0] m, input logic [15:0] p);
        @(negedge clk);
        mode_i = m; preset_i = p; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk2("R1 reset", 16'd0, 1'b1);
        cnt_clk = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 rising edge does not step", count_o, 16'd0);
        cnt_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 stopped after reset", count_o, 16'd0);
    endtask

    task automatic t_mode0();
        load(3'd0, 16'd5);
        chk("R5 out low after load", {15'd0, out_o}, 16'd0);
        tick(); chk2("R3 mode0 start", 16'd5, 1'b0);
        repeat (4) tick();
        chk2("R5 count 1", 16'd1, 1'b0);
        gate_pulse();
        tick(); chk2("R4 gate ignored mode0 / R5 terminal", 16'd0, 1'b1);
        tick(); chk2("R5 stays high after wrap", 16'hFFFF, 1'b1);
    endtask

    task automatic t_mode2();
        load(3'd2, 16'd4);
        tick(); chk2("R7 start", 16'd4, 1'b1);
        tick(); tick(); chk2("R7 count 2", 16'd2, 1'b1);
        tick(); chk2("R7 low at 1", 16'd1, 1'b0);
        tick(); chk2("R7 reload", 16'd4, 1'b1);
        tick();
        load(3'd2, 16'd1);
        tick(); chk2("R2 preset 1 rejected", 16'd2, 1'b1);
        gate_pulse();
        tick(); chk2("R4 gate restart mode2", 16'd4, 1'b1);
        load(3'd7, 16'd9);
        tick(); chk2("R2 mode 7 rejected", 16'd3, 1'b1);
        load(3'd2, 16'd0);
        tick(); chk2("R7 preset 0 start", 16'd0, 1'b1);
        tick(); chk2("R7 preset 0 wrap", 16'hFFFF, 1'b1);
    endtask

    task automatic t_mode3();
        load(3'd3, 16'd6);
        tick(); chk2("R8 even start", 16'd6, 1'b1);
        tick(); chk2("R8 step 2", 16'd4, 1'b1);
        tick(); chk2("R8 at 2", 16'd2, 1'b1);
        tick(); chk2("R8 reload toggle low", 16'd6, 1'b0);
        tick(); tick(); chk2("R8 low at 2", 16'd2, 1'b0);
        tick(); chk2("R8 toggle high", 16'd6, 1'b1);
        load(3'd3, 16'd5);
        tick(); chk2("R8 odd start", 16'd4, 1'b1);
        tick(); chk2("R8 odd at 2", 16'd2, 1'b1);
        tick(); chk2("R8 odd extra high", 16'd2, 1'b1);
        tick(); chk2("R8 odd low", 16'd4, 1'b0);
        tick(); chk2("R8 odd low 2", 16'd2, 1'b0);
        tick(); chk2("R8 odd back high", 16'd4, 1'b1);
        load(3'd3, 16'd0);
        tick(); chk2("R8 zero start", 16'd0, 1'b1);
        tick(); chk2("R8 zero wrap", 16'hFFFE, 1'b1);
    endtask

    task automatic t_mode4();
        load(3'd4, 16'd3);
        tick(); chk2("R9 start", 16'd3, 1'b1);
        tick(); chk2("R10 one step per falling edge", 16'd2, 1'b1);
        tick(); chk2("R9 at 1", 16'd1, 1'b1);
        tick(); chk2("R9 strobe low", 16'd0, 1'b0);
        tick(); chk2("R9 strobe ends", 16'hFFFF, 1'b1);
        gate_pulse();
        tick(); chk2("R4 gate ignored mode4", 16'hFFFE, 1'b1);
    endtask

    task automatic t_mode5();
        load(3'd5, 16'd2);
        tick(); chk2("R3 mode5 waits for gate", 16'hFFFE, 1'b1);
        gate_pulse();
        tick(); chk2("R3 mode5 start", 16'd2, 1'b1);
        tick(); chk2("R9 hw at 1", 16'd1, 1'b1);
        tick(); chk2("R9 hw strobe low", 16'd0, 1'b0);
        tick(); chk2("R9 hw strobe one period", 16'hFFFF, 1'b1);
    endtask

    task automatic t_mode1();
        load(3'd1, 16'd3);
        tick(); chk2("R3 mode1 waits", 16'hFFFF, 1'b1);
        gate_pulse();
        tick(); chk2("R6 start low", 16'd3, 1'b0);
        tick(); chk2("R6 count", 16'd2, 1'b0);
        gate_pulse();
        tick(); chk2("R4 retrigger", 16'd3, 1'b0);
        tick(); tick(); chk2("R6 at 1", 16'd1, 1'b0);
        tick(); chk2("R6 high at 0", 16'd0, 1'b1);
        tick(); chk2("R6 stays high", 16'hFFFF, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode5();
        t_mode1();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule